// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog

This block is a memory-mapped watchdog whose countdown runs in two stages in a row. Each stage has its own 20-bit preload register. A stage lasts `(preload + 1) << PSC_W` clock cycles, because the preload value forms the upper part of a wide down-counter and a fixed all-ones prescale fills its low `PSC_W` bits. When the first stage runs out, the block sets a sticky interrupt flag. In watchdog mode it then starts the second stage. If the second stage also runs out before software reloads the timer, the block pulls an active-low timeout pin low, provided the pin is enabled. In free-running mode only the first stage repeats, and the flag is raised again on each pass.

Software reaches the block through a simple single-cycle register bus. A write is taken on the rising clock edge when `bus_wr` is high, and read data is combinational from `bus_addr`. Writes to the preload registers and to the reload register take effect only if they come straight after a two-word key sequence. A lock bit freezes the control register until reset.

Register words (`bus_addr`):
- 0: first preload
- 1: second preload
- 2: status
- 3: control
- 4: key
- 5: reload

Control bits:
- bit 0: run enable
- bit 1: free-running mode
- bit 2: pin enable
- bit 3: lock

Top module: `wdog2s_top`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `tout_n` is 1.
- R2: The preload words at addresses 0 and 1 hold 20 bits. Bits 31:20 read as 0 whatever value was written.
- R3: After the run-enable bit is set, or after an accepted reload, at edge E, `irq` (status bit 0) reads 1 from edge E + (pre1+1)·2^PSC_W on and reads 0 one cycle earlier.
- R4: Status bit 0 is cleared only by a write to address 2 with bit 0 set. A write with bit 0 at 0 leaves it unchanged, and bits 31:1 read as 0.
- R5: In watchdog mode (control bit 1 = 0) with the pin enabled (control bit 2 = 1), `tout_n` goes low (pre2+1)·2^PSC_W cycles after the first-stage expiry. It stays low until an accepted reload or reset.
- R6: With control bit 2 = 0, `tout_n` stays 1 even after the second stage expires.
- R7: In free-running mode, the first stage reloads itself on every expiry, status bit 0 is set again each time, and `tout_n` never goes low.
- R8: With control bit 0 = 0, the counter holds at the first-stage load value and no expiry happens.
- R9: Once control bit 3 is 1, writes to address 3 are ignored until reset.
- R10: A write to address 0, 1 or 5 is accepted only if it is the next bus write after word 0x5A and then word 0xC3 are written to address 4. Any other key value or intervening write restarts the sequence. A write to address 5 outside this window has no effect on the countdown.
- R11: An accepted reload restarts the first stage from its preload and releases `tout_n`. It leaves status bit 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous |
| bus_addr | input | 3 | Register word select |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | First-stage expiry flag (status bit 0) |
| tout_n | output | 1 | Active-low timeout pin |

## Verification
The countdown is run with small preloads (1 and 2) and a reduced prescale, so that each expiry edge can be predicted exactly and the value one cycle earlier can be checked as well. This separates an off-by-one in the stage length from a wrong stage order. The same preloads are run in three setups:
- watchdog mode with the pin enabled;
- watchdog mode with the pin disabled;
- free-running mode.

These runs distinguish a second-stage expiry that reaches the pin from one that does not, and from a first stage that simply repeats. Key sequences are sent in the right order, with a wrong word in between, and left out altogether. A reload sent with no keys while the timer is running must leave the expiry edge where it was.

// File: rtl/wdog2s_pkg.sv
package wdog2s_pkg;

  typedef enum logic [1:0] {
    ST_ONE  = 2'd0,
    ST_TWO  = 2'd1,
    ST_DONE = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_HALF = 2'd1,
    UL_OPEN = 2'd2
  } unlock_e;

  localparam logic [2:0] A_PRE1   = 3'd0;
  localparam logic [2:0] A_PRE2   = 3'd1;
  localparam logic [2:0] A_STAT   = 3'd2;
  localparam logic [2:0] A_CTRL   = 3'd3;
  localparam logic [2:0] A_KEY    = 3'd4;
  localparam logic [2:0] A_RELOAD = 3'd5;

  localparam int CB_EN   = 0;
  localparam int CB_FREE = 1;
  localparam int CB_OE   = 2;
  localparam int CB_LOCK = 3;
  localparam int CTRL_W  = 4;

endpackage

// File: rtl/wdog2s_regs.sv
module wdog2s_regs
  import wdog2s_pkg::*;
#(
  parameter int          PRE_W = 20,
  parameter logic [31:0] KEY_A = 32'h0000_005A,
  parameter logic [31:0] KEY_B = 32'h0000_00C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              stage1_expire,
  output logic [31:0]       bus_rdata,
  output logic [PRE_W-1:0]  pre1,
  output logic [PRE_W-1:0]  pre2,
  output logic [CTRL_W-1:0] ctrl,
  output logic              status,
  output logic              reload_fire
);

  unlock_e ul_q, ul_d;
  logic    win_open;

  assign win_open    = (ul_q == UL_OPEN);
  assign reload_fire = bus_wr && (bus_addr == A_RELOAD) && win_open;

  always_comb begin
    ul_d = ul_q;
    if (bus_wr) begin
      if (bus_addr == A_KEY) begin
        if (bus_wdata == KEY_A)                         ul_d = UL_HALF;
        else if (ul_q == UL_HALF && bus_wdata == KEY_B) ul_d = UL_OPEN;
        else                                            ul_d = UL_IDLE;
      end else begin
        ul_d = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ul_q   <= UL_IDLE;
      pre1   <= '0;
      pre2   <= '0;
      ctrl   <= '0;
      status <= 1'b0;
    end else begin
      ul_q <= ul_d;
      if (stage1_expire)                                     status <= 1'b1;
      else if (bus_wr && bus_addr == A_STAT && bus_wdata[0]) status <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          A_PRE1: if (win_open) pre1 <= bus_wdata[PRE_W-1:0];
          A_PRE2: if (win_open) pre2 <= bus_wdata[PRE_W-1:0];
          A_CTRL: if (!ctrl[CB_LOCK]) ctrl <= bus_wdata[CTRL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_PRE1:  bus_rdata = {{(32-PRE_W){1'b0}}, pre1};
      A_PRE2:  bus_rdata = {{(32-PRE_W){1'b0}}, pre2};
      A_STAT:  bus_rdata = {31'b0, status};
      A_CTRL:  bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl};
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog2s_counter.sv
module wdog2s_counter
  import wdog2s_pkg::*;
#(
  parameter int PRE_W = 20,
  parameter int PSC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             free_mode,
  input  logic             reload_fire,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  output logic             stage1_expire,
  output logic             stage2_expire,
  output logic             tout_hit,
  output stage_e           stage
);

  localparam int CNT_W = PRE_W + PSC_W;

  function automatic logic [CNT_W-1:0] stage_load(input logic [PRE_W-1:0] pl);
    return {pl, {PSC_W{1'b1}}};
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             at_zero;
  logic             live;

  assign at_zero       = (cnt == '0);
  assign live          = run_en && !reload_fire;
  assign stage1_expire = live && (stage == ST_ONE) && at_zero;
  assign stage2_expire = live && !free_mode && (stage == ST_TWO) && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= ST_ONE;
      cnt      <= '0;
      tout_hit <= 1'b0;
    end else begin
      if (reload_fire)        tout_hit <= 1'b0;
      else if (stage2_expire) tout_hit <= 1'b1;

      if (!run_en || reload_fire) begin
        stage <= ST_ONE;
        cnt   <= stage_load(pre1);
      end else begin
        case (stage)
          ST_ONE: begin
            if (!at_zero)       cnt <= cnt - 1'b1;
            else if (free_mode) cnt <= stage_load(pre1);
            else begin
              stage <= ST_TWO;
              cnt   <= stage_load(pre2);
            end
          end
          ST_TWO: begin
            if (free_mode) begin
              stage <= ST_ONE;
              cnt   <= stage_load(pre1);
            end else if (!at_zero) cnt <= cnt - 1'b1;
            else                   stage <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/wdog2s_top.sv
module wdog2s_top
  import wdog2s_pkg::*;
#(
  parameter int          PRE_W = 20,
  parameter int          PSC_W = 15,
  parameter logic [31:0] KEY_A = 32'h0000_005A,
  parameter logic [31:0] KEY_B = 32'h0000_00C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tout_n
);

  logic [PRE_W-1:0]  pre1, pre2;
  logic [CTRL_W-1:0] ctrl;
  logic              status;
  logic              reload_fire;
  logic              stage1_expire, stage2_expire;
  logic              tout_hit;
  stage_e            stage;

  wdog2s_regs #(.PRE_W(PRE_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) regs_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .stage1_expire (stage1_expire),
    .bus_rdata     (bus_rdata),
    .pre1          (pre1),
    .pre2          (pre2),
    .ctrl          (ctrl),
    .status        (status),
    .reload_fire   (reload_fire)
  );

  wdog2s_counter #(.PRE_W(PRE_W), .PSC_W(PSC_W)) cnt_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_en        (ctrl[CB_EN]),
    .free_mode     (ctrl[CB_FREE]),
    .reload_fire   (reload_fire),
    .pre1          (pre1),
    .pre2          (pre2),
    .stage1_expire (stage1_expire),
    .stage2_expire (stage2_expire),
    .tout_hit      (tout_hit),
    .stage         (stage)
  );

  assign irq    = status;
  assign tout_n = ~(tout_hit & ctrl[CB_OE]);

endmodule

// File: rtl/wdog2s_chk.sv
module wdog2s_chk
  import wdog2s_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic              clr_bit,
  input logic              irq,
  input logic              tout_n,
  input logic              stage1_expire,
  input logic              stage2_expire,
  input logic              reload_fire,
  input logic [CTRL_W-1:0] ctrl_q,
  input stage_e            stage
);

  // R3
  s1_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage1_expire |=> irq);

  // R5
  s2_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_expire && ctrl_q[CB_OE] && !(bus_wr && bus_addr == A_CTRL) |=> !tout_n);

  // R4
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr && bus_addr == A_STAT && clr_bit));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_LOCK] |=> $stable(ctrl_q));

  // R7
  free_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_FREE] && stage1_expire |=> stage == ST_ONE);

  // R11
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire |=> stage == ST_ONE && tout_n);

  // R11
  reload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire && irq |=> irq);

  // R7
  free_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_FREE] && !stage2_expire && tout_n |=> tout_n || !ctrl_q[CB_FREE]);

endmodule

bind wdog2s_top wdog2s_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .clr_bit       (bus_wdata[0]),
  .irq           (irq),
  .tout_n        (tout_n),
  .stage1_expire (stage1_expire),
  .stage2_expire (stage2_expire),
  .reload_fire   (reload_fire),
  .ctrl_q        (ctrl),
  .stage         (stage)
);

// File: tb/wdog2s_top_tb_top.sv
module wdog2s_top_tb_top;

  localparam int PSC = 3;
  localparam int UNIT = 1 << PSC;
  localparam logic [31:0] KA = 32'h5A;
  localparam logic [31:0] KB = 32'hC3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, tout_n;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int last_e = 0;
  bit done = 0;

  typedef struct {
    int    at;
    int    sig;  // 0 irq, 1 tout_n
    logic  val;
    string req;
  } exp_t;
  exp_t exp_q[$];

  wdog2s_top #(.PSC_W(PSC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tout_n(tout_n)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int stage_len(input int pl);
    return (pl + 1) * UNIT;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: compares queued expectations at the negative edge
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      exp_t it;
      logic got;
      it = exp_q.pop_front();
      got = (it.sig == 0) ? irq : tout_n;
      check(got === it.val, it.req, {31'b0, got}, {31'b0, it.val});
    end
  end

  task automatic push(input int at, input int sig, input logic val, input string req);
    exp_t it;
    it.at = at; it.sig = sig; it.val = val; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 last_e = cyc;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic prog(input logic [2:0] a, input logic [31:0] d);
    wr(3'd4, KA);
    wr(3'd4, KB);
    wr(a, d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] expv, input string req);
    @(negedge clk);
    bus_addr = a;
    #1 check(bus_rdata === expv, req, bus_rdata, expv);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) rd(a[2:0], 32'h0, "R1");
    check(irq === 1'b0, "R1", {31'b0, irq}, 32'h0);
    check(tout_n === 1'b1, "R1", {31'b0, tout_n}, 32'h1);

    // R2 width of preload words
    prog(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h000F_FFFF, "R2");
    prog(3'd1, 32'hABC1_2345);
    rd(3'd1, 32'h0001_2345, "R2");

    // R10 broken key sequence, missing keys
    wr(3'd4, KA); wr(3'd4, 32'h11); wr(3'd4, KB); wr(3'd0, 32'h7);
    rd(3'd0, 32'h000F_FFFF, "R10");
    wr(3'd1, 32'h5);
    rd(3'd1, 32'h0001_2345, "R10");
    wr(3'd4, KA); wr(3'd2, 32'h0); wr(3'd4, KB); wr(3'd0, 32'h3);
    rd(3'd0, 32'h000F_FFFF, "R10");
    prog(3'd0, 32'd1);
    prog(3'd1, 32'd2);
    rd(3'd0, 32'd1, "R10");
    rd(3'd1, 32'd2, "R10");

    // R3 / R5 watchdog mode, pin enabled
    wr(3'd3, 32'h5); e = last_e;
    push(e + stage_len(1) - 1, 0, 1'b0, "R3");
    push(e + stage_len(1),     0, 1'b1, "R3");
    push(e + stage_len(1) + stage_len(2) - 1, 1, 1'b1, "R5");
    push(e + stage_len(1) + stage_len(2),     1, 1'b0, "R5");
    push(e + stage_len(1) + stage_len(2) + 20, 1, 1'b0, "R5");
    drain();

    // R4 write-one-to-clear
    rd(3'd2, 32'h1, "R4");
    wr(3'd2, 32'hFFFF_FFFE);
    rd(3'd2, 32'h1, "R4");

    // R11 reload keeps status, releases pin, restarts stage one
    wr(3'd4, KA); wr(3'd4, KB); wr(3'd5, 32'h0); e = last_e;
    push(e + 1, 1, 1'b1, "R11");
    push(e + 1, 0, 1'b1, "R11");
    push(e + stage_len(1) - 1, 0, 1'b0, "R11");
    push(e + stage_len(1),     0, 1'b1, "R11");
    push(e + stage_len(1) + stage_len(2) - 1, 1, 1'b1, "R11");
    push(e + stage_len(1) + stage_len(2),     1, 1'b0, "R11");
    wr(3'd2, 32'h1);
    rd(3'd2, 32'h0, "R4");
    drain();
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h1);

    // R6 pin disabled
    wr(3'd4, KA); wr(3'd4, KB); wr(3'd5, 32'h0);
    wr(3'd3, 32'h1); e = last_e;
    push(e + stage_len(1) - 1, 0, 1'b0, "R6");
    push(e + stage_len(1),     0, 1'b1, "R6");
    push(e + stage_len(1) + stage_len(2),     1, 1'b1, "R6");
    push(e + stage_len(1) + stage_len(2) + 5, 1, 1'b1, "R6");
    drain();
    wr(3'd3, 32'h0);
    wr(3'd4, KA); wr(3'd4, KB); wr(3'd5, 32'h0);
    wr(3'd2, 32'h1);

    // R7 free-running mode
    wr(3'd3, 32'h7); e = last_e;
    push(e + stage_len(1) - 1,     0, 1'b0, "R7");
    push(e + stage_len(1),         0, 1'b1, "R7");
    push(e + 2 * stage_len(1) - 1, 0, 1'b0, "R7");
    push(e + 2 * stage_len(1),     0, 1'b1, "R7");
    push(e + stage_len(1) + stage_len(2) + 10, 1, 1'b1, "R7");
    wait_until(e + stage_len(1) + 2);
    wr(3'd2, 32'h1);
    drain();
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h1);

    // R8 run enable off
    wr(3'd3, 32'h2); e = last_e;
    push(e + stage_len(1) + 4,  0, 1'b0, "R8");
    push(e + 3 * stage_len(1),  0, 1'b0, "R8");
    drain();

    // R9 lock, R10 reload without keys ignored
    wr(3'd3, 32'h9); e = last_e;
    push(e + stage_len(1) - 1, 0, 1'b0, "R10");
    push(e + stage_len(1),     0, 1'b1, "R10");
    rd(3'd3, 32'h9, "R9");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h9, "R9");
    wr(3'd5, 32'h0);
    drain();
    rd(3'd3, 32'h9, "R9");

    done = 1;
  end

  initial begin
    while (!done && cyc < 20000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule